// File: doc/BRIEF.md
# Two-Rank Converter Code Latch

This block is the digital front end of a 12-bit digital-to-analog converter. It assembles a converter code from a data bus, holds it and presents it to the analog core. The first rank holds an 8-bit low byte and a 4-bit high nibble. Each has its own write strobe, so the block suits a narrow bus that writes twice or a wide bus that writes once. A second rank, loaded by a separate strobe, holds the code the converter uses. Every strobe is active low and acts only while the master write enable is also low.

All controls are sampled on the rising clock edge. A byte or nibble strobe given in the same cycle as the load strobe sends its bus bits straight into the second rank, so the last partial write and the update happen in one cycle. A bipolar-zero input forces the output code to mid-scale at once and without the clock, whatever the strobes are doing. A small controller tracks whether the output shows mid-scale (state ZERO) or a loaded word (state LIVE). A power-on reset clears the first rank to zero and puts the controller in ZERO. The output is available as offset binary and as two's complement, where the two's-complement form is the offset-binary code with its MSB inverted.

Controller states and transitions: ZERO → LIVE on a transfer (write enable and load strobe low at a clock edge, bipolar-zero input high). LIVE → LIVE on any further transfer. ZERO → ZERO while no transfer occurs. Any state → ZERO at once when the bipolar-zero input or the power-on reset goes low.

Top module: `dac_word_latch`

## Requirements
- R1: With `wr_n`=0 and `lo_n`=0 at a rising edge, the low byte register takes `data_i[7:0]`. Otherwise it keeps its value.
- R2: With `wr_n`=0 and `hi_n`=0 at a rising edge, the high nibble register takes `data_i[11:8]`. Otherwise it keeps its value.
- R3: With `wr_n`=0 and `load_n`=0 at a rising edge (`zero_n`=1), `code_o` shows {nibble, byte} of the first rank from that edge on.
- R4: In a transfer cycle, a field whose own strobe is also active takes its bits from `data_i` rather than from the first rank.
- R5: While `wr_n`=1, no strobe alters either rank. A later transfer shows the first rank as it was before.
- R6: While `zero_n`=0, `code_o` is 0x800 immediately and without waiting for a clock, even when a transfer is requested.
- R7: After `zero_n` returns high, `code_o` stays 0x800 until the next transfer. The first rank is not cleared by `zero_n`, and writes made while it was low are kept.
- R8: `por_n`=0 sets `code_o` to 0x800 and clears the first rank, so a transfer with no prior write gives 0x000.
- R9: `code_tc_o` equals `code_o` with bit 11 inverted. For example, 0x800 gives 0x000 and 0x7FF gives 0xFFF.
- R10: An edge with `load_n`=1 or `wr_n`=1 leaves `code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| data_i | input | 12 | Data bus; bit 11 is the MSB |
| wr_n | input | 1 | Master write enable, active low |
| load_n | input | 1 | Second-rank load strobe, active low |
| lo_n | input | 1 | Low byte strobe, active low |
| hi_n | input | 1 | High nibble strobe, active low |
| zero_n | input | 1 | Force bipolar zero, asynchronous, active low |
| code_o | output | 12 | Converter code, offset binary |
| code_tc_o | output | 12 | Converter code, two's complement |

## Verification
The functions that can meet in one cycle are a first-rank write and the second-rank transfer, and also the bipolar-zero override and a full transfer. The bench drives byte or nibble strobes together with the load strobe on the major-carry codes 0x7FF, 0x8FF and 0x800, and judges the forwarded fields against a behavioural model. It holds `zero_n` low across an edge where every strobe is active. The output must stay 0x800, and the word written during that edge must appear only at the next transfer after release.

// File: rtl/dwl_pkg.sv
`timescale 1ns/1ps
package dwl_pkg;
    localparam int unsigned LO_W   = 8;
    localparam int unsigned HI_W   = 4;
    localparam int unsigned CODE_W = LO_W + HI_W;

    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_LIVE = 1'b1
    } dwl_state_t;
endpackage

// File: rtl/dwl_seg.sv
`timescale 1ns/1ps
module dwl_seg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)  q <= '0;
        else if (we) q <= d;
    end

    // value the segment holds after this edge: lets a same-cycle write flow on
    assign nxt = we ? d : q;
endmodule

// File: rtl/dwl_ctrl.sv
`timescale 1ns/1ps
module dwl_ctrl
    import dwl_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       zero_n,
    input  logic       wr_n,
    input  logic       load_n,
    input  logic       lo_n,
    input  logic       hi_n,
    output logic       lo_we,
    output logic       hi_we,
    output logic       xfer,
    output dwl_state_t state
);
    dwl_state_t state_nx;

    always_ff @(posedge clk or negedge por_n or negedge zero_n) begin
        if (!por_n || !zero_n) state <= ST_ZERO;
        else                   state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ZERO: if (xfer) state_nx = ST_LIVE;
            ST_LIVE: state_nx = ST_LIVE;
            default: state_nx = ST_ZERO;
        endcase
    end

    always_comb begin
        lo_we = !wr_n && !lo_n;
        hi_we = !wr_n && !hi_n;
        xfer  = !wr_n && !load_n;
    end
endmodule

// File: rtl/dac_word_latch.sv
`timescale 1ns/1ps
module dac_word_latch
    import dwl_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [CODE_W-1:0] data_i,
    input  logic              wr_n,
    input  logic              load_n,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic              zero_n,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] code_tc_o
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

    logic              lo_we, hi_we, xfer;
    dwl_state_t        state;
    logic [LO_W-1:0]   lo_q, lo_nxt;
    logic [HI_W-1:0]   hi_q, hi_nxt;
    logic [CODE_W-1:0] code_q;

    dwl_ctrl u_ctrl (
        .clk(clk), .por_n(por_n), .zero_n(zero_n),
        .wr_n(wr_n), .load_n(load_n), .lo_n(lo_n), .hi_n(hi_n),
        .lo_we(lo_we), .hi_we(hi_we), .xfer(xfer), .state(state)
    );

    dwl_seg #(.W(LO_W)) u_lo (
        .clk(clk), .por_n(por_n), .we(lo_we),
        .d(data_i[LO_W-1:0]), .q(lo_q), .nxt(lo_nxt)
    );

    dwl_seg #(.W(HI_W)) u_hi (
        .clk(clk), .por_n(por_n), .we(hi_we),
        .d(data_i[CODE_W-1:LO_W]), .q(hi_q), .nxt(hi_nxt)
    );

    // second rank: only loaded when the override is not holding it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                code_q <= MID;
        else if (xfer && zero_n)   code_q <= {hi_nxt, lo_nxt};
    end

    always_comb begin
        code_o    = (state == ST_ZERO) ? MID : code_q;
        code_tc_o = code_o ^ MID;
    end
endmodule

// File: rtl/dwl_chk.sv
`timescale 1ns/1ps
module dwl_chk #(
    parameter int unsigned CODE_W = 12
) (
    input logic              clk,
    input logic              por_n,
    input logic [CODE_W-1:0] data_i,
    input logic              wr_n,
    input logic              load_n,
    input logic              lo_n,
    input logic              hi_n,
    input logic              zero_n,
    input logic [CODE_W-1:0] code_o,
    input logic [CODE_W-1:0] code_tc_o
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

    assert_zero_force_R6: assert property (@(posedge clk) disable iff (!por_n)
        !zero_n |-> code_o == MID);

    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(zero_n) |-> code_o == MID);

    assert_full_flow_R4: assert property (@(posedge clk) disable iff (!por_n)
        (zero_n && $past(zero_n) && $past(por_n) &&
         $past(!wr_n && !load_n && !lo_n && !hi_n)) |-> code_o == $past(data_i));

    assert_no_load_R10: assert property (@(posedge clk) disable iff (!por_n)
        (zero_n && $past(zero_n) && $past(por_n) && $past(load_n)) |-> $stable(code_o));

    assert_wr_gate_R5: assert property (@(posedge clk) disable iff (!por_n)
        (zero_n && $past(zero_n) && $past(por_n) && $past(wr_n)) |-> $stable(code_o));

    assert_tc_mid_R9: assert property (@(posedge clk) disable iff (!por_n)
        code_o == MID |-> code_tc_o == '0);

    assert_tc_top_R9: assert property (@(posedge clk) disable iff (!por_n)
        code_o == MID - 1'b1 |-> code_tc_o == '1);
endmodule

bind dac_word_latch dwl_chk #(.CODE_W(dwl_pkg::CODE_W)) u_chk (
    .clk(clk), .por_n(por_n), .data_i(data_i), .wr_n(wr_n),
    .load_n(load_n), .lo_n(lo_n), .hi_n(hi_n), .zero_n(zero_n),
    .code_o(code_o), .code_tc_o(code_tc_o)
);

// File: tb/dac_word_latch_tb.sv
`timescale 1ns/1ps
module dac_word_latch_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [11:0] data_i = '0;
    logic        wr_n = 1'b1, load_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1, zero_n = 1'b1;
    logic [11:0] code_o, code_tc_o;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R3";

    // behavioural reference
    logic [7:0]  lo_m = '0;
    logic [3:0]  hi_m = '0;
    logic [11:0] code_m = 12'h800;
    logic [7:0]  nlo;
    logic [3:0]  nhi;
    logic [11:0] exp_c;

    always #2.5 clk = ~clk;

    dac_word_latch u_dut (
        .clk(clk), .por_n(por_n), .data_i(data_i), .wr_n(wr_n),
        .load_n(load_n), .lo_n(lo_n), .hi_n(hi_n), .zero_n(zero_n),
        .code_o(code_o), .code_tc_o(code_tc_o)
    );

    always @(posedge clk) begin
        if (!por_n) begin
            lo_m = '0; hi_m = '0; code_m = 12'h800;
        end else begin
            nlo = (!wr_n && !lo_n) ? data_i[7:0]  : lo_m;
            nhi = (!wr_n && !hi_n) ? data_i[11:8] : hi_m;
            if (!zero_n)                code_m = 12'h800;
            else if (!wr_n && !load_n)  code_m = {nhi, nlo};
            lo_m = nlo; hi_m = nhi;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            exp_c = (!zero_n || !por_n) ? 12'h800 : code_m;
            n_chk++;
            if (code_o !== exp_c) begin
                n_fail++;
                $display("FAIL %s model: code_o=%03h expected %03h", cur_req, code_o, exp_c);
            end
            n_chk++;
            if (code_tc_o !== (exp_c ^ 12'h800)) begin
                n_fail++;
                $display("FAIL R9 model: code_tc_o=%03h expected %03h", code_tc_o, exp_c ^ 12'h800);
            end
        end
    end

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    // apply levels (active low strobes), let one rising edge sample them
    task automatic step(input logic w, input logic ld, input logic lo, input logic hi,
                        input logic zr, input logic [11:0] d);
        wr_n = w; load_n = ld; lo_n = lo; hi_n = hi; zero_n = zr; data_i = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        @(posedge clk); #1;
        chk(code_o, 12'h800, "R8 reset code");
        chk(code_tc_o, 12'h000, "R9 reset tc");
        por_n = 1'b1;

        cur_req = "R8";
        step(0, 0, 1, 1, 1, 12'hFFF);
        chk(code_o, 12'h000, "R8 transfer without writes");

        cur_req = "R10";
        step(0, 1, 0, 1, 1, 12'h0A5);
        chk(code_o, 12'h000, "R10 byte write no load");
        step(0, 1, 1, 0, 1, 12'h3C0);
        chk(code_o, 12'h000, "R10 nibble write no load");
        cur_req = "R3";
        step(0, 0, 1, 1, 1, 12'hFFF);
        chk(code_o, 12'h3A5, "R3 R1 R2 byte nibble transfer");

        cur_req = "R4";
        step(0, 1, 1, 0, 1, 12'h700);
        step(0, 0, 0, 1, 1, 12'h0FF);
        chk(code_o, 12'h7FF, "R4 byte flows with load");
        chk(code_tc_o, 12'hFFF, "R9 tc of 7FF");
        step(0, 0, 1, 0, 1, 12'h800);
        chk(code_o, 12'h8FF, "R4 nibble flows with load");
        step(0, 0, 0, 0, 1, 12'h800);
        chk(code_o, 12'h800, "R4 both flow with load");
        chk(code_tc_o, 12'h000, "R9 tc of 800");

        cur_req = "R5";
        step(1, 0, 0, 0, 1, 12'hC3C);
        chk(code_o, 12'h800, "R5 strobes with wr high");
        step(0, 0, 1, 1, 1, 12'h000);
        chk(code_o, 12'h800, "R5 first rank untouched");

        cur_req = "R10";
        step(0, 1, 0, 0, 1, 12'h123);
        chk(code_o, 12'h800, "R10 load high");
        step(1, 1, 1, 1, 1, 12'hEEE);
        chk(code_o, 12'h800, "R10 idle");
        cur_req = "R3";
        step(0, 0, 1, 1, 1, 12'h000);
        chk(code_o, 12'h123, "R3 transfer of 123");

        cur_req = "R6";
        zero_n = 1'b0;
        #1;
        chk(code_o, 12'h800, "R6 asynchronous force");
        step(0, 0, 0, 0, 0, 12'hABC);
        chk(code_o, 12'h800, "R6 overrides transfer");
        cur_req = "R7";
        step(1, 1, 1, 1, 1, 12'h000);
        chk(code_o, 12'h800, "R7 held after release");
        step(0, 1, 1, 1, 1, 12'h000);
        chk(code_o, 12'h800, "R7 still held");
        step(0, 0, 1, 1, 1, 12'h000);
        chk(code_o, 12'hABC, "R7 first rank kept write");
        step(1, 1, 1, 1, 1, 12'h000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule